// File: doc/BRIEF.md
# Descriptor Staging and Commit Queue

This block is the host-facing entry point of a DMA engine. A host writes an eight-word transfer descriptor one 32-bit word at a time into a small register window. Word slots 0 to 6 (read address low, write address low, byte count, burst/sequence, stride, read address high, write address high) are only staged. Slot 7 is the control word. When it is written with its go bit (bit 31) set, the seven staged words and the incoming control word are pushed into a descriptor queue as one 256-bit entry in a single cycle, so a consumer never sees a half-written descriptor.

The queue head is offered downstream on a valid/ready stream. An entry leaves on a cycle where `desc_valid` and `desc_ready` are both high. While `desc_ready` is low the head is held unchanged, so back-pressure stalls the queue and never loses data. Plain status pins give empty, full, a fill word and a sticky overflow flag. The staged words are kept after a commit, so the next descriptor only needs writes to the words that change. The block does not interpret burst, stride or control fields. It carries them into the queue untouched.

Top module: `desc_commit_fe`

## Requirements
- R1: After reset `buf_empty`=1, `buf_full`=0, `desc_valid`=0, `overflow`=0 and `fill_word` = {DEPTH, 0}.
- R2: A write to slot 7 with bit 31 set pushes one entry. Entry word k (bits 32k+31:32k) is staged slot k for k<7, and word 7 is the written control value. If the queue was empty, the entry is at `desc_data` with `desc_valid`=1 on the cycle after the write.
- R3: Writes to slots 0 to 6, and writes to slot 7 with bit 31 clear, never change the queue occupancy.
- R4: Staged words keep their values across a commit. A later commit after rewriting only some slots carries the old values in the other slots.
- R5: Entries leave in commit order, one on each cycle where `desc_valid` and `desc_ready` are both high. While `desc_valid`=1 and `desc_ready`=0, `desc_data` stays stable and `desc_valid` stays high.
- R6: `buf_empty` is 1 exactly when the queue holds 0 entries and `buf_full` is 1 exactly when it holds DEPTH entries. `fill_word[15:0]` is the number of held entries and `fill_word[31:16]` is the number of free slots.
- R7: A commit while the queue is full and no entry leaves in that cycle is dropped. It sets `overflow`, which stays 1 until reset.
- R8: A commit and a pop in the same cycle both take effect and leave occupancy unchanged. This includes a full queue, where the commit is accepted and not dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Window write strobe |
| wr_addr | input | 3 | Word slot index 0..7 |
| wr_data | input | 32 | Write data |
| desc_valid | output | 1 | Queue head is valid |
| desc_ready | input | 1 | Consumer accepts the head |
| desc_data | output | 256 | Queue head descriptor, word 0 in bits 31:0 |
| buf_empty | output | 1 | Queue holds no entries |
| buf_full | output | 1 | Queue holds DEPTH entries |
| fill_word | output | 32 | Free slots in 31:16, held entries in 15:0 |
| overflow | output | 1 | Sticky: a commit was dropped |

## Verification
A commit from the host and a pop by the consumer can land on the same clock edge. This case matters most at the two ends of the queue. At empty, the pop has nothing to take. At full, the pop frees the slot that the commit needs. The bench fills the queue to every level from 0 to DEPTH and then issues a commit with `desc_ready` high and one with it low. A cycle-accurate model in the bench tracks the expected entries, and each cycle it compares occupancy, head contents and the overflow flag against that model.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 8;
  localparam int ADDR_W    = $clog2(NUM_WORDS);
  localparam int DESC_W    = WORD_W * NUM_WORDS;
  localparam int CTL_SLOT  = NUM_WORDS - 1;
  localparam int GO_BIT    = 31;
  localparam int LVL_W     = 16;
  typedef logic [DESC_W-1:0] desc_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/dfe_stage.sv
module dfe_stage
  import dfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  word_t             wr_data,
  output desc_t             commit_desc,
  output logic              commit_req
);
  word_t slots [NUM_WORDS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (!rst_n) slots[i] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(i))) slots[i] <= wr_data;
    end
  end

  assign commit_req = wr_en && (wr_addr == ADDR_W'(CTL_SLOT)) && wr_data[GO_BIT];

  always_comb begin
    for (int k = 0; k < CTL_SLOT; k++) commit_desc[k*WORD_W +: WORD_W] = slots[k];
    commit_desc[CTL_SLOT*WORD_W +: WORD_W] = wr_data;
  end
endmodule

// File: rtl/dfe_fifo.sv
module dfe_fifo
  import dfe_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  desc_t            push_data,
  input  logic             pop,
  output desc_t            head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic             dropped
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  desc_t mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic accept, do_pop;

  assign do_pop  = pop && (count != '0);
  assign accept  = push_req && ((count != CW'(DEPTH)) || do_pop);
  assign dropped = push_req && !accept;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (accept) wptr <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop) rptr <= (rptr == PW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({accept, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/desc_commit_fe.sv
module desc_commit_fe
  import dfe_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  output logic                 desc_valid,
  input  logic                 desc_ready,
  output logic [DESC_W-1:0]    desc_data,
  output logic                 buf_empty,
  output logic                 buf_full,
  output logic [2*LVL_W-1:0]   fill_word,
  output logic                 overflow
);
  localparam int CW = $clog2(DEPTH+1);

  desc_t          staged_desc;
  logic           commit_req;
  logic [CW-1:0]  count;
  logic           dropped;

  dfe_stage u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit_desc(staged_desc), .commit_req(commit_req)
  );

  dfe_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_req(commit_req), .push_data(staged_desc),
    .pop(desc_valid && desc_ready), .head(desc_data), .count(count),
    .dropped(dropped)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       overflow <= 1'b0;
    else if (dropped) overflow <= 1'b1;
  end

  assign desc_valid = (count != '0);
  assign buf_empty  = (count == '0);
  assign buf_full   = (count == CW'(DEPTH));
  assign fill_word  = {LVL_W'(DEPTH) - LVL_W'(count), LVL_W'(count)};
endmodule

// File: rtl/desc_commit_fe_chk.sv
module desc_commit_fe_chk
  import dfe_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [WORD_W-1:0]    wr_data,
  input logic                 desc_valid,
  input logic                 desc_ready,
  input logic [DESC_W-1:0]    desc_data,
  input logic                 buf_empty,
  input logic                 buf_full,
  input logic [2*LVL_W-1:0]   fill_word,
  input logic                 overflow
);
  logic go_wr, popping;
  assign go_wr   = wr_en && (wr_addr == ADDR_W'(CTL_SLOT)) && wr_data[GO_BIT];
  assign popping = desc_valid && desc_ready;

  a_r2_commit_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && !buf_full) |=> (desc_valid && !buf_empty));

  a_r3_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_wr && !popping) |=> $stable(fill_word));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_data)));

  a_r6_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_full && buf_empty) && (fill_word[15:0] + fill_word[31:16] == 16'(DEPTH)));

  a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && buf_full && !desc_ready) |=> (overflow && buf_full));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r8_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && popping) |=> ($stable(fill_word) && !overflow == !$past(overflow)));
endmodule

bind desc_commit_fe desc_commit_fe_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_data(desc_data),
  .buf_empty(buf_empty), .buf_full(buf_full), .fill_word(fill_word),
  .overflow(overflow)
);

// File: tb/desc_commit_fe_tb.sv
module desc_commit_fe_tb;
  localparam int D = 4;

  logic         clk = 0;
  logic         rst_n;
  logic         wr_en;
  logic [2:0]   wr_addr;
  logic [31:0]  wr_data;
  logic         desc_valid, desc_ready;
  logic [255:0] desc_data;
  logic         buf_empty, buf_full, overflow;
  logic [31:0]  fill_word;

  int checks = 0;
  int errors = 0;

  logic [31:0]  m_stage [8];
  logic [255:0] m_q [$];
  logic         m_ovf;

  always #5 clk = ~clk;

  desc_commit_fe #(.DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_data(desc_data),
    .buf_empty(buf_empty), .buf_full(buf_full), .fill_word(fill_word),
    .overflow(overflow)
  );

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int sz = m_q.size();
    chk(desc_valid == (sz > 0), tag, "valid", 256'(desc_valid), 256'(sz > 0));
    chk(buf_empty == (sz == 0), tag, "empty", 256'(buf_empty), 256'(sz == 0));
    chk(buf_full == (sz == D), tag, "full", 256'(buf_full), 256'(sz == D));
    chk(fill_word == {16'(D - sz), 16'(sz)}, tag, "fill",
        256'(fill_word), 256'({16'(D - sz), 16'(sz)}));
    chk(overflow == m_ovf, tag, "overflow", 256'(overflow), 256'(m_ovf));
    if (sz > 0) chk(desc_data == m_q[0], tag, "head", desc_data, m_q[0]);
  endtask

  // called at a negedge; returns at the following negedge after checking
  task automatic cyc(input logic we, input logic [2:0] a, input logic [31:0] d,
                     input logic rdy, input string tag);
    logic commit, pop, acc;
    logic [255:0] ent;
    wr_en = we; wr_addr = a; wr_data = d; desc_ready = rdy;
    commit = we && (a == 3'd7) && d[31];
    pop    = rdy && (m_q.size() > 0);
    acc    = commit && ((m_q.size() < D) || pop);
    for (int k = 0; k < 7; k++) ent[k*32 +: 32] = m_stage[k];
    ent[255:224] = d;
    @(negedge clk);
    if (we) m_stage[a] = d;
    if (pop) void'(m_q.pop_front());
    if (acc) m_q.push_back(ent);
    if (commit && !acc) m_ovf = 1'b1;
    check_all(tag);
  endtask

  function automatic logic [31:0] pat(input int n, input int k);
    return {8'(n), 8'(k), 16'hA5C0 + 16'(k)};
  endfunction

  function automatic logic [31:0] ctlw(input int n);
    return 32'h8000_0000 | {8'h00, 8'(n), 4'h6, 4'h3, 8'(n + 1)};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; desc_ready = 0; m_ovf = 0;
    for (int k = 0; k < 8; k++) m_stage[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check_all("R1");

    // R3: staging writes do not enqueue
    for (int k = 0; k < 7; k++) cyc(1, 3'(k), pat(0, k), 0, "R3");
    cyc(1, 3'd7, ctlw(0) & 32'h7FFF_FFFF, 0, "R3");
    // R2: commit pushes the assembled descriptor
    cyc(1, 3'd7, ctlw(0), 0, "R2");
    cyc(0, 3'd0, 32'h0, 0, "R2");
    // R4: rewrite only the length word, then commit
    cyc(1, 3'd2, 32'h0000_1000, 0, "R4");
    cyc(1, 3'd7, ctlw(1), 0, "R4");
    // R6: fill to full
    cyc(1, 3'd5, pat(2, 5), 0, "R6");
    cyc(1, 3'd7, ctlw(2), 0, "R6");
    cyc(1, 3'd7, ctlw(3), 0, "R6");
    // R7: commit while full without pop is dropped
    cyc(1, 3'd7, ctlw(4), 0, "R7");
    cyc(0, 3'd0, 32'h0, 0, "R7");
    // R8: commit and pop together while full
    cyc(1, 3'd7, ctlw(5), 1, "R8");
    // R5: drain under back-pressure toggling
    for (int i = 0; i < 10; i++) cyc(0, 3'd0, 32'h0, logic'(i % 2), "R5");

    // R8 sweep: at each fill level, commit with ready high then low
    for (int f = 0; f <= D; f++) begin
      while (m_q.size() > 0) cyc(0, 3'd0, 32'h0, 1, "R5");
      for (int j = 0; j < f; j++) begin
        cyc(1, 3'd1, pat(f, j), 0, "R4");
        cyc(1, 3'd7, ctlw(f * 8 + j), 0, "R6");
      end
      cyc(1, 3'd7, ctlw(100 + f), 1, "R8");
      cyc(1, 3'd7, ctlw(120 + f), 0, "R7");
    end
    while (m_q.size() > 0) cyc(0, 3'd0, 32'h0, 1, "R5");
    cyc(0, 3'd0, 32'h0, 1, "R6");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule